// File: doc/BRIEF.md
# Two-Wire Bus Occupancy Monitor with Stale-Busy Timeout

This block watches the clock and data lines of a shared two-wire bus and keeps a flag that says whether some master currently owns the bus. A Start condition sets the flag and a Stop condition clears it. The lines are expected to arrive already synchronized to the local clock. Arbitration and the generation of Start or Stop are handled elsewhere.

The flag can stay set on a bus that has gone silent. This happens when two masters detect a conflict and both withdraw at once: each still sees the bus as taken and waits for a Stop that never comes. To break this, a counter measures how many cycles both lines have gone without an edge while the flag is set. When the count reaches a programmable limit, the block raises a sticky timeout flag. Software can then clear the busy flag and go on. When the block is enabled in the middle of another device's transaction, the busy flag reads zero. A master should therefore wait one timeout period of bus silence before it asks for the bus.

Top module: `busmon_top`

## Requirements
- R1: A Start condition sets `busBusy` at the next clock edge, provided the block is enabled and `swClear` is low. A Start is SDA sampled 1 and then 0 on consecutive cycles while SCL is sampled 1 on both cycles.
- R2: A Stop condition clears `busBusy` at the next clock edge. A Stop is SDA sampled 0 and then 1 while SCL is sampled 1 on both cycles.
- R3: SDA changes while SCL is low leave `busBusy` unchanged.
- R4: Take limit L on `idleLimit` and a bus with no edges after the Start. `idleTimeout` is low L clock edges after the edge that set `busBusy`. It is high one edge later. This holds for L = 0 as well.
- R5: Any edge on SCL or SDA while busy restarts the quiet count. `idleTimeout` then rises L+1 edges after the clock edge that sampled the line edge.
- R6: `idleTimeout` is never high while `busBusy` is low, and it clears in the same cycle that a Stop clears `busBusy`.
- R7: Once `idleTimeout` is set, it stays set across later SCL or SDA edges until a Stop, a software clear or a disable.
- R8: A high `swClear` clears both flags at the next edge. It takes priority over a Start seen in the same cycle.
- R9: While `enable` is low, both flags are forced to zero at each edge, and Start conditions are ignored.
- R10: After `enable` rises during a transaction that is already running, `busBusy` stays low until a new Start is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronized SCL line level |
| sdaIn | input | 1 | Synchronized SDA line level |
| enable | input | 1 | Module enable; low forces both flags to zero |
| swClear | input | 1 | Software clear of the busy and timeout flags |
| idleLimit | input | CNT_W | Number of quiet cycles at which the timeout is raised |
| busBusy | output | 1 | Bus-occupied flag |
| idleTimeout | output | 1 | Sticky stale-busy flag |

## Verification
The assertions assume that `sclIn` and `sdaIn` are already synchronous to `clk` and stable between edges, so that one sampled transition stands for one line event. They also assume that `idleLimit` is held constant for as long as the flag is busy. The bench changes the lines and the controls only one time unit after a rising edge. It changes the limit only while the bus is idle, and it changes a single line per cycle. It sweeps the limit over 0 to 12 and checks the timeout edge exactly at L and L+1 cycles each time.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

  // Line events reported by the datapath to the control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic lineEdge;
    logic atLimit;
  } busEvents_t;

  // Counter strobes issued by the control to the datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } cntStrobes_t;

endpackage

// File: rtl/busmon_datapath.sv
module busmon_datapath
  import busmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [CNT_W-1:0] idleLimit,
  input  cntStrobes_t      strobes,
  output busEvents_t       events
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             sclQ;
  logic             sdaQ;
  logic [CNT_W-1:0] quietCnt;

  // Line samples run even while disabled so that enabling creates no false edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
    end else if (strobes.cntClear) begin
      quietCnt <= '0;
    end else if (strobes.cntStep) begin
      quietCnt <= quietCnt + CNT_ONE;
    end
  end

  logic sclHeld;
  assign sclHeld = sclQ & sclIn;

  always_comb begin
    events.startDet = sclHeld & sdaQ & ~sdaIn;
    events.stopDet  = sclHeld & ~sdaQ & sdaIn;
    events.lineEdge = (sclQ ^ sclIn) | (sdaQ ^ sdaIn);
    events.atLimit  = (quietCnt >= idleLimit);
  end

endmodule

// File: rtl/busmon_control.sv
module busmon_control
  import busmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        swClear,
  input  busEvents_t  events,
  output cntStrobes_t strobes,
  output logic        busBusy,
  output logic        idleTimeout
);

  logic busyQ;
  logic busyNext;
  logic toutQ;
  logic toutNext;

  always_comb begin
    if (!enable || swClear)      busyNext = 1'b0;
    else if (events.startDet)    busyNext = 1'b1;
    else if (events.stopDet)     busyNext = 1'b0;
    else                         busyNext = busyQ;
  end

  always_comb begin
    if (!enable || swClear || !busyNext) toutNext = 1'b0;
    else if (busyQ && events.atLimit)    toutNext = 1'b1;
    else                                 toutNext = toutQ;
  end

  // Quiet count restarts while not busy or on any line edge, and saturates at the limit
  always_comb begin
    strobes.cntClear = !busyQ || events.lineEdge;
    strobes.cntStep  = !events.atLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      toutQ <= 1'b0;
    end else begin
      busyQ <= busyNext;
      toutQ <= toutNext;
    end
  end

  assign busBusy     = busyQ;
  assign idleTimeout = toutQ;

endmodule

// File: rtl/busmon_top.sv
module busmon_top
  import busmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             enable,
  input  logic             swClear,
  input  logic [CNT_W-1:0] idleLimit,
  output logic             busBusy,
  output logic             idleTimeout
);

  busEvents_t  events;
  cntStrobes_t strobes;

  busmon_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .idleLimit (idleLimit),
    .strobes   (strobes),
    .events    (events)
  );

  busmon_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .swClear     (swClear),
    .events      (events),
    .strobes     (strobes),
    .busBusy     (busBusy),
    .idleTimeout (idleTimeout)
  );

endmodule

// File: rtl/busmon_checker.sv
module busmon_checker (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic enable,
  input logic swClear,
  input logic busBusy,
  input logic idleTimeout
);

  logic sclP;
  logic sdaP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclIn;
      sdaP <= sdaIn;
    end
  end

  logic startSeen;
  logic stopSeen;
  logic sclLowBoth;
  assign startSeen  = sclP && sclIn && sdaP && !sdaIn;
  assign stopSeen   = sclP && sclIn && !sdaP && sdaIn;
  assign sclLowBoth = !sclP && !sclIn;

  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !swClear && startSeen) |=> busBusy);

  a_r2_stop_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !swClear && stopSeen) |=> !busBusy);

  a_r3_scl_low_holds_busy: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !swClear && sclLowBoth) |=> (busBusy == $past(busBusy)));

  a_r6_timeout_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    idleTimeout |-> busBusy);

  a_r8_clear_drops_flags: assert property (@(posedge clk) disable iff (!rstN)
    swClear |=> (!busBusy && !idleTimeout));

  a_r9_disable_drops_flags: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!busBusy && !idleTimeout));

endmodule

bind busmon_top busmon_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .sclIn       (sclIn),
  .sdaIn       (sdaIn),
  .enable      (enable),
  .swClear     (swClear),
  .busBusy     (busBusy),
  .idleTimeout (idleTimeout)
);

// File: tb/busmon_top_bench.sv
module busmon_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int MAX_LIMIT  = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sclIn = 1'b1;
  logic             sdaIn = 1'b1;
  logic             enable = 1'b0;
  logic             swClear = 1'b0;
  logic [CNT_W-1:0] idleLimit = '0;
  logic             busBusy;
  logic             idleTimeout;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busmon_top #(.CNT_W(CNT_W)) u_busmon_top (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .enable      (enable),
    .swClear     (swClear),
    .idleLimit   (idleLimit),
    .busBusy     (busBusy),
    .idleTimeout (idleTimeout)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Start from an idle bus: SCL and SDA both high
  task automatic busStart();
    sdaIn = 1'b0;
    step();
  endtask

  // Stop from SCL high with SDA low
  task automatic busStop();
    sdaIn = 1'b1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check("reset busy", busBusy, 1'b0);
    check("reset timeout", idleTimeout, 1'b0);
    rstN = 1'b1;
    enable = 1'b1;
    step();

    // R4 sweep over limits; R1, R2, R6, R7 in each pass
    for (int lim = 0; lim <= MAX_LIMIT; lim++) begin
      idleLimit = CNT_W'(lim);
      step();
      busStart();
      check("R1 start sets busy", busBusy, 1'b1);
      repeat (lim) step();
      check("R4 timeout low at L", idleTimeout, 1'b0);
      step();
      check("R4 timeout high at L+1", idleTimeout, 1'b1);
      sclIn = 1'b0;
      step();
      check("R7 sticky across SCL fall", idleTimeout, 1'b1);
      sclIn = 1'b1;
      step();
      check("R7 sticky across SCL rise", idleTimeout, 1'b1);
      busStop();
      check("R2 stop clears busy", busBusy, 1'b0);
      check("R6 stop clears timeout", idleTimeout, 1'b0);
    end

    // R5: a line edge restarts the quiet count
    idleLimit = CNT_W'(6);
    step();
    busStart();
    repeat (4) step();
    sclIn = 1'b0;
    step();
    repeat (6) step();
    check("R5 timeout low L after edge", idleTimeout, 1'b0);
    step();
    check("R5 timeout high L+1 after edge", idleTimeout, 1'b1);
    sclIn = 1'b1;
    step();
    busStop();
    check("R2 stop clears busy", busBusy, 1'b0);

    // R3: SDA moves with SCL low, both when idle and when busy
    sclIn = 1'b0;
    step();
    sdaIn = 1'b0;
    step();
    check("R3 idle SDA fall with SCL low", busBusy, 1'b0);
    sdaIn = 1'b1;
    step();
    check("R3 idle SDA rise with SCL low", busBusy, 1'b0);
    sclIn = 1'b1;
    step();
    busStart();
    sclIn = 1'b0;
    step();
    sdaIn = 1'b1;
    step();
    check("R3 busy SDA rise with SCL low", busBusy, 1'b1);
    sdaIn = 1'b0;
    step();
    sclIn = 1'b1;
    step();
    busStop();

    // R8: software clear, and its priority over a Start
    idleLimit = CNT_W'(2);
    step();
    busStart();
    repeat (3) step();
    check("R8 timeout before clear", idleTimeout, 1'b1);
    swClear = 1'b1;
    step();
    check("R8 clear drops busy", busBusy, 1'b0);
    check("R8 clear drops timeout", idleTimeout, 1'b0);
    swClear = 1'b0;
    busStop();
    swClear = 1'b1;
    sdaIn = 1'b0;
    step();
    check("R8 clear beats start", busBusy, 1'b0);
    swClear = 1'b0;
    busStop();

    // R9: disable forces zero and ignores Starts
    busStart();
    repeat (3) step();
    enable = 1'b0;
    step();
    check("R9 disable drops busy", busBusy, 1'b0);
    check("R9 disable drops timeout", idleTimeout, 1'b0);
    busStop();
    busStart();
    check("R9 start ignored while disabled", busBusy, 1'b0);

    // R10: enabling in mid transaction leaves busy low until a new Start
    enable = 1'b1;
    step();
    check("R10 busy low after enable", busBusy, 1'b0);
    sclIn = 1'b0;
    step();
    sdaIn = 1'b1;
    step();
    sdaIn = 1'b0;
    step();
    check("R10 busy low during data", busBusy, 1'b0);
    sclIn = 1'b1;
    step();
    busStop();
    check("R10 busy low after stop", busBusy, 1'b0);
    busStart();
    check("R10 new start sets busy", busBusy, 1'b1);
    busStop();
    check("R2 final stop", busBusy, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule